// File: doc/BRIEF.md
# Frequency Table Search Engine

The block keeps a small table of supported output frequencies. Each slot pairs a 32-bit frequency with four divider settings: reference, output, feedback and bandwidth. Software or a loader fills the slots through a write port. Queries then walk the table one slot per clock and return either the slot that matches a request exactly or the nearest supported frequency at or below the request.

The table is meant to hold its entries in descending order of frequency. The usable length ends at the first slot whose frequency is zero, so a short table needs no separate count. A round query uses the descending order: the first slot at or below the request is the nearest one. If every valid slot is above the request, the round query falls back to the last valid slot, which is the smallest frequency.

Requests use a valid/ready handshake. The engine handles one query at a time and reports the result with a one-cycle response strobe.

Top module: `freq_table_search`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every table slot holds frequency zero.
- R2: An exact query (`req_mode`=0) whose frequency appears in the table returns `rsp_found`=1, together with the index, frequency and four divider values of the lowest-indexed slot holding that frequency.
- R3: An exact query whose frequency does not appear among the valid slots returns `rsp_found`=0. In that case `rsp_freq`, `rsp_index` and all divider outputs are zero.
- R4: A round query (`req_mode`=1) returns `rsp_found`=1 and the lowest-indexed valid slot whose frequency is less than or equal to the request.
- R5: A round query for which every valid slot exceeds the request returns `rsp_found`=1 and the last valid slot.
- R6: The valid length is the number of slots before the first slot with frequency zero. Slots after that one are never returned by either kind of query.
- R7: When slot 0 has frequency zero, every query returns `rsp_found`=0 with all result fields zero.
- R8: Slots are examined one per clock, starting at slot 0. The response strobe rises k+1 clock edges after the accepting edge, where k is the index of the slot that ends the walk: the hit, the zero terminator, or slot DEPTH-1.
- R9: `req_ready` is 0 from the edge after a request is accepted until the response cycle has passed. `rsp_valid` is high for exactly one cycle per accepted request.
- R10: When no slot is zero, all DEPTH slots are valid. A round query below every frequency then returns slot DEPTH-1.
- R11: With `wr_en`=1, a clock edge stores the frequency and all four dividers into slot `wr_addr`. A later query returns these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW | Slot to write |
| wr_freq | input | 32 | Frequency to store (0 = terminator) |
| wr_nr | input | 6 | Reference divider to store |
| wr_no | input | 4 | Output divider to store |
| wr_nf | input | 13 | Feedback divider to store |
| wr_nb | input | 12 | Bandwidth setting to store |
| req_valid | input | 1 | Query request valid |
| req_ready | output | 1 | Engine idle and able to accept a query |
| req_mode | input | 1 | 0 = exact match, 1 = round down |
| req_freq | input | 32 | Requested frequency |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_found | output | 1 | A slot was returned |
| rsp_index | output | AW | Index of the returned slot |
| rsp_freq | output | 32 | Frequency of the returned slot |
| rsp_nr | output | 6 | Reference divider of the returned slot |
| rsp_no | output | 4 | Output divider of the returned slot |
| rsp_nf | output | 13 | Feedback divider of the returned slot |
| rsp_nb | output | 12 | Bandwidth setting of the returned slot |

## Verification
On every cycle the assertions check the handshake rules: the response is a single-cycle pulse, `req_ready` stays low while a walk is in progress, and any event that ends the walk is followed by a response. On each response they also check that a not-found result carries zero fields and that an exact hit echoes the requested frequency. Only the bench scenarios can show which slot is selected. That covers the first-match order when frequencies repeat, the fallback to the smallest slot, stale slots hidden behind a terminator, a full table with no terminator, and the exact latency for each walk length.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int FREQ_W = 32;
  localparam int NR_W   = 6;
  localparam int NO_W   = 4;
  localparam int NF_W   = 13;
  localparam int NB_W   = 12;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [NR_W-1:0]   nr;
    logic [NO_W-1:0]   no;
    logic [NF_W-1:0]   nf;
    logic [NB_W-1:0]   nb;
  } fts_entry_t;

  typedef enum logic {
    QRY_EXACT = 1'b0,
    QRY_ROUND = 1'b1
  } qry_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RESP = 2'd2
  } scan_st_t;

  // A slot with zero frequency ends the valid part of the table
  function automatic logic fts_is_term(input fts_entry_t e);
    return (e.freq == '0);
  endfunction

  // Does a slot satisfy the query?
  function automatic logic fts_hit(input qry_t mode,
                                   input logic [FREQ_W-1:0] slot_f,
                                   input logic [FREQ_W-1:0] want_f);
    if (mode == QRY_EXACT) return (slot_f == want_f);
    return (slot_f <= want_f);
  endfunction
endpackage

// File: rtl/fts_table.sv
module fts_table
  import fts_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [AW-1:0] wr_addr,
  input  fts_entry_t   wr_entry,
  input  logic [AW-1:0] rd_addr,
  output fts_entry_t   rd_entry
);
  fts_entry_t slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        slots[g] <= wr_entry;
      end
    end
  end

  assign rd_entry = slots[rd_addr];
endmodule

// File: rtl/fts_scan.sv
module fts_scan
  import fts_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  qry_t              req_mode,
  input  logic [FREQ_W-1:0] req_freq,
  output logic              req_ready,
  output logic [AW-1:0]     rd_addr,
  input  fts_entry_t        rd_entry,
  output logic              rsp_valid,
  output logic              rsp_found,
  output logic [AW-1:0]     rsp_index,
  output fts_entry_t        rsp_entry,
  output logic              scan_active,
  output logic              ev_hit,
  output logic              ev_term,
  output logic              ev_end,
  output qry_t              q_mode,
  output logic [FREQ_W-1:0] q_freq
);
  scan_st_t   state;
  logic [AW-1:0] idx;
  fts_entry_t prev;

  logic          done;
  logic          res_found;
  logic [AW-1:0] res_idx;
  fts_entry_t    res_entry;

  assign scan_active = (state == ST_SCAN);
  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
  assign rd_addr     = idx;

  assign ev_term = scan_active && fts_is_term(rd_entry);
  assign ev_hit  = scan_active && !ev_term && fts_hit(q_mode, rd_entry.freq, q_freq);
  assign ev_end  = scan_active && !ev_term && !ev_hit && (idx == AW'(DEPTH-1));
  assign done    = ev_term || ev_hit || ev_end;

  always_comb begin
    res_found = 1'b0;
    res_idx   = '0;
    res_entry = '0;
    if (ev_hit) begin
      res_found = 1'b1;
      res_idx   = idx;
      res_entry = rd_entry;
    end else if (ev_term) begin
      if ((idx != '0) && (q_mode == QRY_ROUND)) begin
        res_found = 1'b1;
        res_idx   = idx - AW'(1);
        res_entry = prev;
      end
    end else if (ev_end) begin
      if (q_mode == QRY_ROUND) begin
        res_found = 1'b1;
        res_idx   = idx;
        res_entry = rd_entry;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      prev      <= '0;
      q_mode    <= QRY_EXACT;
      q_freq    <= '0;
      rsp_found <= 1'b0;
      rsp_index <= '0;
      rsp_entry <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            q_mode <= req_mode;
            q_freq <= req_freq;
            idx    <= '0;
            prev   <= '0;
            state  <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (done) begin
            rsp_found <= res_found;
            rsp_index <= res_idx;
            rsp_entry <= res_entry;
            state     <= ST_RESP;
          end else begin
            prev <= rd_entry;
            idx  <= idx + AW'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/freq_table_search.sv
module freq_table_search
  import fts_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_freq,
  input  logic [5:0]    wr_nr,
  input  logic [3:0]    wr_no,
  input  logic [12:0]   wr_nf,
  input  logic [11:0]   wr_nb,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_mode,
  input  logic [31:0]   req_freq,
  output logic          rsp_valid,
  output logic          rsp_found,
  output logic [AW-1:0] rsp_index,
  output logic [31:0]   rsp_freq,
  output logic [5:0]    rsp_nr,
  output logic [3:0]    rsp_no,
  output logic [12:0]   rsp_nf,
  output logic [11:0]   rsp_nb
);
  fts_entry_t    wr_entry;
  fts_entry_t    rd_entry;
  fts_entry_t    rsp_entry;
  logic [AW-1:0] rd_addr;
  logic          scan_active;
  logic          ev_hit;
  logic          ev_term;
  logic          ev_end;
  qry_t          q_mode;
  logic [31:0]   q_freq;

  assign wr_entry = '{freq: wr_freq, nr: wr_nr, no: wr_no, nf: wr_nf, nb: wr_nb};

  fts_table #(.DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_entry (wr_entry),
    .rd_addr  (rd_addr),
    .rd_entry (rd_entry)
  );

  fts_scan #(.DEPTH(DEPTH)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mode    (qry_t'(req_mode)),
    .req_freq    (req_freq),
    .req_ready   (req_ready),
    .rd_addr     (rd_addr),
    .rd_entry    (rd_entry),
    .rsp_valid   (rsp_valid),
    .rsp_found   (rsp_found),
    .rsp_index   (rsp_index),
    .rsp_entry   (rsp_entry),
    .scan_active (scan_active),
    .ev_hit      (ev_hit),
    .ev_term     (ev_term),
    .ev_end      (ev_end),
    .q_mode      (q_mode),
    .q_freq      (q_freq)
  );

  assign rsp_freq = rsp_entry.freq;
  assign rsp_nr   = rsp_entry.nr;
  assign rsp_no   = rsp_entry.no;
  assign rsp_nf   = rsp_entry.nf;
  assign rsp_nb   = rsp_entry.nb;
endmodule

// File: rtl/fts_check.sv
module fts_check
  import fts_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_found,
  input logic [31:0] rsp_freq,
  input logic        ev_hit,
  input logic        ev_term,
  input logic        ev_end,
  input qry_t        q_mode,
  input logic [31:0] q_freq
);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  busy_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R8
  done_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit || ev_term || ev_end) |=> rsp_valid);

  // R3
  nf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_found) |-> (rsp_freq == '0));

  // R2
  exact_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_found && (q_mode == QRY_EXACT)) |-> (rsp_freq == q_freq));
endmodule

bind freq_table_search fts_check u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_found (rsp_found),
  .rsp_freq  (rsp_freq),
  .ev_hit    (ev_hit),
  .ev_term   (ev_term),
  .ev_end    (ev_end),
  .q_mode    (q_mode),
  .q_freq    (q_freq)
);

// File: tb/freq_table_search_test.sv
`timescale 1ns/1ps
module freq_table_search_test;
  localparam int D  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_freq = '0;
  logic [5:0]    wr_nr = '0;
  logic [3:0]    wr_no = '0;
  logic [12:0]   wr_nf = '0;
  logic [11:0]   wr_nb = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_mode = 1'b0;
  logic [31:0]   req_freq = '0;
  logic          rsp_valid;
  logic          rsp_found;
  logic [AW-1:0] rsp_index;
  logic [31:0]   rsp_freq;
  logic [5:0]    rsp_nr;
  logic [3:0]    rsp_no;
  logic [12:0]   rsp_nf;
  logic [11:0]   rsp_nb;

  freq_table_search #(.DEPTH(D)) uut (.*);

  always #4 clk = ~clk;

  typedef struct {
    string       tag;
    bit          found;
    int unsigned idx;
    int unsigned freq;
    int unsigned nr, no, nf, nb;
    int          lat;
    int          acc;
  } exp_t;

  exp_t        sb[$];
  int          n_run = 0, n_fail = 0;
  int          cyc = 0;
  bit          finished = 0;
  bit          prev_v = 0;
  int unsigned m_f [D];
  int unsigned m_r [D], m_o [D], m_n [D], m_b [D];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, string what, longint act, longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // model from the requirements
  function automatic exp_t model(bit mode, int unsigned f);
    exp_t e;
    e.found = 0; e.idx = 0; e.freq = 0;
    e.nr = 0; e.no = 0; e.nf = 0; e.nb = 0; e.lat = D;
    for (int i = 0; i < D; i++) begin
      int pick = -1;
      bit stop = 0;
      if (m_f[i] == 0) begin
        stop = 1;
        if (i > 0 && mode) pick = i - 1;
      end else if ((!mode && m_f[i] == f) || (mode && m_f[i] <= f)) begin
        stop = 1; pick = i;
      end else if (i == D - 1) begin
        stop = 1;
        if (mode) pick = i;
      end
      if (stop) begin
        e.lat = i + 1;
        if (pick >= 0) begin
          e.found = 1; e.idx = pick; e.freq = m_f[pick];
          e.nr = m_r[pick]; e.no = m_o[pick]; e.nf = m_n[pick]; e.nb = m_b[pick];
        end
        break;
      end
    end
    return e;
  endfunction

  task automatic wr(int a, int unsigned f, int unsigned r, int unsigned o,
                    int unsigned n, int unsigned b);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_freq = f;
    wr_nr = 6'(r); wr_no = 4'(o); wr_nf = 13'(n); wr_nb = 12'(b);
    m_f[a] = f; m_r[a] = r & 63; m_o[a] = o & 15; m_n[a] = n & 8191; m_b[a] = b & 4095;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic query(string tag, bit mode, int unsigned f);
    exp_t e;
    e = model(mode, f);
    e.tag = tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_mode = mode; req_freq = f;
    @(posedge clk);
    #1;
    e.acc = cyc;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        chk(!prev_v, "R9", "response longer than one cycle", 1, 0);
        chk(!req_ready, "R9", "ready during response", req_ready, 0);
        if (sb.size() == 0) begin
          chk(0, "R9", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          bit ok;
          e = sb.pop_front();
          ok = (rsp_found == e.found) && (rsp_index == AW'(e.idx)) &&
               (rsp_freq == e.freq) && (rsp_nr == 6'(e.nr)) && (rsp_no == 4'(e.no)) &&
               (rsp_nf == 13'(e.nf)) && (rsp_nb == 12'(e.nb));
          if (!ok)
            $display("FAIL %s detail found=%0d/%0d idx=%0d/%0d nr=%0d/%0d no=%0d/%0d nf=%0d/%0d nb=%0d/%0d",
                     e.tag, rsp_found, e.found, rsp_index, e.idx, rsp_nr, e.nr,
                     rsp_no, e.no, rsp_nf, e.nf, rsp_nb, e.nb);
          chk(ok, e.tag, "result freq", rsp_freq, e.freq);
          chk((cyc - e.acc) == e.lat, "R8", {e.tag, " latency"}, cyc - e.acc, e.lat);
        end
      end
      prev_v = rsp_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      m_f[i] = 0; m_r[i] = 0; m_o[i] = 0; m_n[i] = 0; m_b[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready after release", req_ready, 1);

    // R7 / R1: table empty after reset
    query("R7_exact_empty", 0, 100);
    query("R7_round_empty", 1, 100);

    // R11: short descending table with terminator at slot 5
    wr(0, 1200, 1, 1, 50, 25);
    wr(1, 1000, 2, 2, 41, 20);
    wr(2, 800,  3, 3, 33, 16);
    wr(3, 600,  4, 4, 25, 12);
    wr(4, 408,  5, 5, 17, 8);
    query("R2_exact_mid", 0, 800);
    query("R2_exact_last", 0, 408);
    query("R3_exact_miss", 0, 700);
    query("R4_round_between", 1, 900);
    query("R4_round_equal", 1, 1000);
    query("R4_round_above_all", 1, 5000);
    query("R5_round_below_all", 1, 100);

    // R6: stale slot after terminator stays hidden
    wr(6, 300, 9, 9, 9, 9);
    query("R6_exact_hidden", 0, 300);
    query("R6_round_hidden", 1, 350);

    // R10: full table, no terminator
    for (int i = 0; i < D; i++)
      wr(i, (D - i) * 100, i + 10, i, 300 + i, 400 + i);
    query("R10_round_min", 1, 50);
    query("R10_exact_last_slot", 0, 100);
    query("R2_exact_first", 0, D * 100);

    // R2: repeated frequency, first slot wins
    wr(3, (D - 2) * 100, 60, 7, 999, 777);
    query("R2_exact_duplicate", 0, (D - 2) * 100);
    query("R4_round_duplicate", 1, (D - 2) * 100 + 50);

    // R7: slot 0 cleared makes the whole table empty
    wr(0, 0, 0, 0, 0, 0);
    query("R7_round_cleared", 1, 5000);
    query("R7_exact_cleared", 0, 1500);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R9", "pending responses", sb.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule